// File: doc/BRIEF.md
# Two-Bank Flash Erase Sequencer with Page Locks

This block takes erase commands for a flash array split into two banks, a low one and a high one. Each bank has its own page-erase and half-array mass-erase command. Before an erase is started, the target is checked against a per-page lock vector, a mass-erase unlock input and a bypass key. An accepted erase raises a per-bank busy flag and runs a programmable duration counter. That counter advances on a clock-enable tick taken from a slower timing clock. At the end, the block pulses done and clears the command bits itself. A refused erase produces a one-cycle lock-error pulse and clears its command without ever going busy.

Software writes a 32-bit command word and reads it back. It then polls busy or waits for the done and lock-error events. A debug port has its own request line per bank. That line starts a mass erase only while a separate debug key input holds the magic value. The two banks run independently, so both may erase at once.

Top module: `flerase_ctrl`

## Requirements
- R1: After synchronous reset, the read-back command word is 0 and busy, done and lock-error are low in both banks.
- R2: Command word layout: low-bank page index in bits [6:0] and high-bank page index in bits [14:8]. Bit 28 requests a low mass erase and bit 29 a high mass erase. Bit 30 requests a low page erase and bit 31 a high page erase. All other bits are ignored on write and read back as 0.
- R3: A page erase is refused when lock bit (bank*128 + index) is set, where bank is 0 for low and 1 for high. The refusal is a lock-error pulse of exactly one cycle, one cycle after the command is registered. The command bit is cleared and busy never rises.
- R4: A mass erase is refused unless the mass-unlock input is 1 and no lock bit of the target bank is set. Locks in the other bank have no effect on the target bank.
- R5: While the erase-key input equals 0xCA1E093F, page and mass erases skip the lock and mass-unlock checks.
- R6: An accepted erase raises busy one cycle after the command is registered. Busy stays high for N ticks, where N is the duration input captured at acceptance and N=0 behaves as 1. Done then pulses for one cycle, and both command bits of that bank read 0.
- R7: While tick is low, a running erase keeps busy high and does not complete.
- R8: When a bank has both its mass and page bits set, the mass erase rules decide, and both bits are cleared at the end.
- R9: While a bank is busy, writes leave its index and command bits unchanged. The other bank's fields still load from the same write.
- R10: A debug mass-erase request starts a mass erase of its bank only while the debug-key input equals 0xCA1E093F. That erase ignores locks and the mass-unlock input. With any other key the request has no effect.
- R11: The two banks can be busy in the same cycle, and each completes on its own count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timing-clock enable; one pulse per erase-timer step |
| cmd_wr_i | input | 1 | Write strobe for the command word |
| cmd_word_i | input | 32 | Command word to write |
| cmd_word_o | output | 32 | Command word read-back |
| erase_cycles_i | input | TIMER_W | Erase duration in ticks |
| lock_vec_i | input | 2*PAGES | Page lock bits, low bank first |
| mass_unlock_i | input | 1 | 1 permits mass erase |
| erase_key_i | input | 32 | Firmware bypass key |
| dbg_key_i | input | 32 | Debug mass-erase key |
| dbg_mass_req_i | input | 2 | Debug mass-erase request, one bit per bank |
| busy_o | output | 2 | Erase in progress, per bank |
| done_o | output | 2 | One-cycle erase-complete pulse, per bank |
| lock_err_o | output | 2 | One-cycle refused-erase pulse, per bank |

## Verification
The bench builds the block with its defaults: 128 pages per bank and a 20-bit timer. With 128 pages, the lock indices 0 and 127 are in reach, as is the step across the bank boundary at bit 128, so a stray bank offset shows up as a wrong verdict. Durations are programmed from 0 to 8 ticks. That keeps every erase within a few cycles, so the bench can count busy exactly and can cover the zero-count case, a gated tick and two overlapping erases.

// File: rtl/flerase_pkg.sv
package flerase_pkg;

    localparam int          NUM_BANKS   = 2;
    localparam int          IDX_STRIDE  = 8;
    localparam int          MASS_BASE   = 28;
    localparam int          PAGE_BASE   = 30;
    localparam logic [31:0] ERASE_MAGIC = 32'hCA1E_093F;

    typedef enum logic {
        ENG_IDLE,
        ENG_RUN
    } eng_state_e;

    typedef enum logic [1:0] {
        VERDICT_NONE,
        VERDICT_GO,
        VERDICT_DENY
    } verdict_e;

    typedef struct packed {
        logic dbg_req;
        logic mass_req;
        logic page_req;
    } bank_req_t;

    function automatic logic key_matches(input logic [31:0] key);
        return key == ERASE_MAGIC;
    endfunction

endpackage

// File: rtl/fe_lock_check.sv
module fe_lock_check
    import flerase_pkg::*;
#(
    parameter int PAGES = 128
) (
    input  logic [PAGES-1:0]         locks_i,
    input  logic [$clog2(PAGES)-1:0] idx_i,
    input  bank_req_t                req_i,
    input  logic                     mass_open_i,
    input  logic                     bypass_i,
    output verdict_e                 verdict_o
);

    logic page_locked;
    logic any_locked;

    assign page_locked = locks_i[idx_i];
    assign any_locked  = |locks_i;

    always_comb begin
        verdict_o = VERDICT_NONE;
        if (req_i.dbg_req) begin
            verdict_o = VERDICT_GO;
        end else if (req_i.mass_req) begin
            verdict_o = (bypass_i || (mass_open_i && !any_locked)) ? VERDICT_GO : VERDICT_DENY;
        end else if (req_i.page_req) begin
            verdict_o = (bypass_i || !page_locked) ? VERDICT_GO : VERDICT_DENY;
        end
    end

endmodule

// File: rtl/fe_bank_engine.sv
module fe_bank_engine
    import flerase_pkg::*;
#(
    parameter int TIMER_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  verdict_e           verdict_i,
    input  logic [TIMER_W-1:0] limit_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               deny_o,
    output logic               clear_o
);

    localparam int CW = TIMER_W + 1;

    eng_state_e         st_q;
    logic [TIMER_W-1:0] cnt_q;
    logic [TIMER_W-1:0] lim_q;
    logic [CW-1:0]      cnt_next;
    logic               last_tick;

    assign cnt_next  = {1'b0, cnt_q} + CW'(1);
    assign last_tick = tick_i && (cnt_next >= {1'b0, lim_q});
    assign busy_o    = (st_q == ENG_RUN);
    assign clear_o   = ((st_q == ENG_IDLE) && (verdict_i == VERDICT_DENY)) ||
                       ((st_q == ENG_RUN) && last_tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ENG_IDLE;
            cnt_q  <= '0;
            lim_q  <= '0;
            done_o <= 1'b0;
            deny_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            deny_o <= 1'b0;
            case (st_q)
                ENG_IDLE: begin
                    if (verdict_i == VERDICT_GO) begin
                        st_q  <= ENG_RUN;
                        cnt_q <= '0;
                        lim_q <= (limit_i == '0) ? TIMER_W'(1) : limit_i;
                    end else if (verdict_i == VERDICT_DENY) begin
                        deny_o <= 1'b1;
                    end
                end
                ENG_RUN: begin
                    if (tick_i) begin
                        if (last_tick) begin
                            st_q   <= ENG_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + TIMER_W'(1);
                        end
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flerase_ctrl.sv
module flerase_ctrl
    import flerase_pkg::*;
#(
    parameter int PAGES   = 128,
    parameter int TIMER_W = 20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick_i,
    input  logic                   cmd_wr_i,
    input  logic [31:0]            cmd_word_i,
    output logic [31:0]            cmd_word_o,
    input  logic [TIMER_W-1:0]     erase_cycles_i,
    input  logic [2*PAGES-1:0]     lock_vec_i,
    input  logic                   mass_unlock_i,
    input  logic [31:0]            erase_key_i,
    input  logic [31:0]            dbg_key_i,
    input  logic [NUM_BANKS-1:0]   dbg_mass_req_i,
    output logic [NUM_BANKS-1:0]   busy_o,
    output logic [NUM_BANKS-1:0]   done_o,
    output logic [NUM_BANKS-1:0]   lock_err_o
);

    localparam int IDX_W = $clog2(PAGES);

    logic [IDX_W-1:0]     idx_q [NUM_BANKS];
    logic [NUM_BANKS-1:0] mass_q;
    logic [NUM_BANKS-1:0] page_q;
    logic [NUM_BANKS-1:0] wr_ok;
    logic [NUM_BANKS-1:0] clear;
    bank_req_t            req     [NUM_BANKS];
    verdict_e             verdict [NUM_BANKS];
    logic                 bypass;
    logic                 dbg_open;
    logic                 unused_word_bits;

    assign bypass           = key_matches(erase_key_i);
    assign dbg_open         = key_matches(dbg_key_i);
    assign unused_word_bits = ^cmd_word_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                idx_q[b] <= '0;
            end
            mass_q <= '0;
            page_q <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (wr_ok[b]) begin
                    idx_q[b]  <= cmd_word_i[b*IDX_STRIDE +: IDX_W];
                    mass_q[b] <= cmd_word_i[MASS_BASE + b];
                    page_q[b] <= cmd_word_i[PAGE_BASE + b];
                end else if (clear[b]) begin
                    mass_q[b] <= 1'b0;
                    page_q[b] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        cmd_word_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            cmd_word_o[b*IDX_STRIDE +: IDX_W] = idx_q[b];
            cmd_word_o[MASS_BASE + b]         = mass_q[b];
            cmd_word_o[PAGE_BASE + b]         = page_q[b];
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign wr_ok[b]        = cmd_wr_i && !busy_o[b];
        assign req[b].dbg_req  = dbg_mass_req_i[b] && dbg_open;
        assign req[b].mass_req = mass_q[b];
        assign req[b].page_req = page_q[b];

        fe_lock_check #(
            .PAGES(PAGES)
        ) u_check (
            .locks_i     (lock_vec_i[b*PAGES +: PAGES]),
            .idx_i       (idx_q[b]),
            .req_i       (req[b]),
            .mass_open_i (mass_unlock_i),
            .bypass_i    (bypass),
            .verdict_o   (verdict[b])
        );

        fe_bank_engine #(
            .TIMER_W(TIMER_W)
        ) u_engine (
            .clk       (clk),
            .rst       (rst),
            .tick_i    (tick_i),
            .verdict_i (verdict[b]),
            .limit_i   (erase_cycles_i),
            .busy_o    (busy_o[b]),
            .done_o    (done_o[b]),
            .deny_o    (lock_err_o[b]),
            .clear_o   (clear[b])
        );
    end

endmodule

// File: rtl/flerase_ctrl_chk.sv
module flerase_ctrl_chk
    import flerase_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_i,
    input logic [3:0]           ctl_bits_i,
    input logic [IDX_W-1:0]     idx0_i,
    input logic [IDX_W-1:0]     idx1_i,
    input logic [NUM_BANKS-1:0] busy_o,
    input logic [NUM_BANKS-1:0] done_o,
    input logic [NUM_BANKS-1:0] lock_err_o
);

    logic [IDX_W-1:0] idx_of [NUM_BANKS];
    assign idx_of[0] = idx0_i;
    assign idx_of[1] = idx1_i;

    // R1: nothing is active in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (busy_o == '0 && done_o == '0 && lock_err_o == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        // R3: a refused erase never runs
        a_r3_deny_not_busy: assert property (@(posedge clk) disable iff (rst)
            lock_err_o[b] |-> !busy_o[b]);

        // R6: done follows a busy period
        a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
            done_o[b] |-> (!busy_o[b] && $past(busy_o[b])));

        // R6: busy only ends together with done
        a_r6_busy_ends_in_done: assert property (@(posedge clk) disable iff (rst)
            busy_o[b] |=> (busy_o[b] || done_o[b]));

        // R6: command bits of the bank are clear once done fires
        a_r6_done_clears_bits: assert property (@(posedge clk) disable iff (rst)
            done_o[b] |-> (!ctl_bits_i[b] && !ctl_bits_i[2 + b]));

        // R7: without a tick the erase cannot finish
        a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
            (busy_o[b] && !tick_i) |=> busy_o[b]);

        // R9: index field of a busy bank is frozen
        a_r9_index_frozen: assert property (@(posedge clk) disable iff (rst)
            (busy_o[b] && $past(busy_o[b])) |-> $stable(idx_of[b]));
    end

endmodule

bind flerase_ctrl flerase_ctrl_chk #(
    .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .ctl_bits_i (cmd_word_o[31:28]),
    .idx0_i     (cmd_word_o[IDX_W-1:0]),
    .idx1_i     (cmd_word_o[IDX_STRIDE +: IDX_W]),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .lock_err_o (lock_err_o)
);

// File: tb/test_flerase_ctrl.sv
module test_flerase_ctrl;

    localparam int          PAGES   = 128;
    localparam int          TIMER_W = 20;
    localparam logic [31:0] MAGIC   = 32'hCA1E_093F;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 tick_i = 1'b1;
    logic                 cmd_wr_i = 1'b0;
    logic [31:0]          cmd_word_i = '0;
    logic [31:0]          cmd_word_o;
    logic [TIMER_W-1:0]   erase_cycles_i = '0;
    logic [2*PAGES-1:0]   lock_vec_i = '0;
    logic                 mass_unlock_i = 1'b0;
    logic [31:0]          erase_key_i = '0;
    logic [31:0]          dbg_key_i = '0;
    logic [1:0]           dbg_mass_req_i = '0;
    logic [1:0]           busy_o;
    logic [1:0]           done_o;
    logic [1:0]           lock_err_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    flerase_ctrl #(.PAGES(PAGES), .TIMER_W(TIMER_W)) i_flerase_ctrl (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cmd_wr_i(cmd_wr_i),
        .cmd_word_i(cmd_word_i), .cmd_word_o(cmd_word_o),
        .erase_cycles_i(erase_cycles_i), .lock_vec_i(lock_vec_i),
        .mass_unlock_i(mass_unlock_i), .erase_key_i(erase_key_i),
        .dbg_key_i(dbg_key_i), .dbg_mass_req_i(dbg_mass_req_i),
        .busy_o(busy_o), .done_o(done_o), .lock_err_o(lock_err_o)
    );

    // op: 0 page low, 1 page high, 2 mass low, 3 mass high
    typedef struct packed {
        logic [1:0] op;
        logic [6:0] idx;
        logic       lock_hit;
        logic       lock_other;
        logic       key_ok;
        logic       unlock;
        logic [3:0] cyc;
        logic       exp_run;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 7'd5,   1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1},
        '{2'd0, 7'd5,   1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0},
        '{2'd0, 7'd5,   1'b1, 1'b0, 1'b1, 1'b0, 4'd2, 1'b1},
        '{2'd1, 7'd127, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 1'b1},
        '{2'd1, 7'd127, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 1'b0},
        '{2'd2, 7'd0,   1'b0, 1'b0, 1'b0, 1'b1, 4'd5, 1'b1},
        '{2'd2, 7'd0,   1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 1'b0},
        '{2'd3, 7'd64,  1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0},
        '{2'd3, 7'd64,  1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 1'b1},
        '{2'd2, 7'd77,  1'b0, 1'b1, 1'b0, 1'b1, 4'd2, 1'b1},
        '{2'd0, 7'd0,   1'b1, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0},
        '{2'd1, 7'd0,   1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1}
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic write_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_word_i = w;
        cmd_wr_i   = 1'b1;
        @(negedge clk);
        cmd_wr_i   = 1'b0;
    endtask

    task automatic observe(input int bank, input int n, output int nb, output int nd, output int ne);
        nb = 0; nd = 0; ne = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy_o[bank])     nb++;
            if (done_o[bank])     nd++;
            if (lock_err_o[bank]) ne++;
        end
    endtask

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary_and_end();
    end

    initial begin
        int nb, nd, ne, nb2, nd2, ne2;
        logic all_busy, saw_done, both_busy;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", "cmd word", cmd_word_o, 32'h0);
        chk("R1", "busy/done/err", {26'd0, busy_o, done_o, lock_err_o}, 32'h0);

        // R2: field placement and ignored bits
        write_cmd(32'h0FFF_D5AA);
        chk("R2", "readback", cmd_word_o, 32'h0000_552A);

        // table walk: R3 R4 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            vec_t  v;
            int    bank;
            int    expb;
            string tag;
            logic [31:0] w;
            v    = VECS[k];
            bank = int'(v.op[0]);
            tag  = v.key_ok ? "R5" : (v.op[1] ? "R4" : "R3");
            lock_vec_i = '0;
            if (v.lock_hit)   lock_vec_i[bank*PAGES + int'(v.idx)] = 1'b1;
            if (v.lock_other) lock_vec_i[(1-bank)*PAGES + int'(v.idx)] = 1'b1;
            erase_key_i    = v.key_ok ? MAGIC : 32'h0;
            mass_unlock_i  = v.unlock;
            erase_cycles_i = TIMER_W'(v.cyc);
            tick_i         = 1'b1;
            w = '0;
            w[bank*8 +: 7] = v.idx;
            w[(v.op[1] ? 28 : 30) + bank] = 1'b1;
            write_cmd(w);
            observe(bank, 24, nb, nd, ne);
            expb = v.exp_run ? ((v.cyc == 0) ? 1 : int'(v.cyc)) : 0;
            chk("R6", $sformatf("vec%0d busy cycles", k), nb, expb);
            chk(tag, $sformatf("vec%0d done pulses", k), nd, {31'd0, v.exp_run});
            chk(tag, $sformatf("vec%0d lock-error pulses", k), ne, {31'd0, !v.exp_run});
            chk(tag, $sformatf("vec%0d command bits cleared", k), {28'd0, cmd_word_o[31:28]}, 32'h0);
        end

        // R8: mass and page together, mass rules decide (unlock low -> refused)
        lock_vec_i = '0; erase_key_i = '0; mass_unlock_i = 1'b0; erase_cycles_i = 3;
        write_cmd(32'h5000_0003);
        observe(0, 12, nb, nd, ne);
        chk("R8", "mass governs: lock-error", ne, 1);
        chk("R8", "mass governs: busy", nb, 0);
        chk("R8", "both bits cleared", {28'd0, cmd_word_o[31:28]}, 32'h0);

        // R7: timer frozen without tick
        tick_i = 1'b0; erase_cycles_i = 2;
        write_cmd(32'h4000_0009);
        all_busy = 1'b1; saw_done = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            all_busy = all_busy & busy_o[0];
            saw_done = saw_done | done_o[0];
        end
        chk("R7", "busy held with no tick", {31'd0, all_busy}, 1);
        chk("R7", "no done with no tick", {31'd0, saw_done}, 0);
        tick_i = 1'b1;
        observe(0, 12, nb, nd, ne);
        chk("R7", "busy after tick resumes", nb, 1);
        chk("R7", "done after tick resumes", nd, 1);

        // R9 / R11: write during busy, concurrent banks
        erase_cycles_i = 8;
        write_cmd(32'h4000_000A);
        @(negedge clk);
        write_cmd(32'h8000_1463);
        chk("R9", "busy low index frozen", {25'd0, cmd_word_o[6:0]}, 32'd10);
        chk("R9", "busy low page bit kept", {31'd0, cmd_word_o[30]}, 1);
        chk("R9", "idle high index loaded", {25'd0, cmd_word_o[14:8]}, 32'd20);
        both_busy = 1'b0; nd = 0; nd2 = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy_o == 2'b11) both_busy = 1'b1;
            if (done_o[0]) nd++;
            if (done_o[1]) nd2++;
        end
        chk("R11", "both banks busy together", {31'd0, both_busy}, 1);
        chk("R11", "low bank done", nd, 1);
        chk("R11", "high bank done", nd2, 1);

        // R10: debug mass erase key gating
        lock_vec_i = '1; mass_unlock_i = 1'b0; erase_key_i = '0; erase_cycles_i = 3;
        dbg_key_i = 32'h1234_5678;
        @(negedge clk); dbg_mass_req_i = 2'b01;
        @(negedge clk); dbg_mass_req_i = 2'b00;
        observe(0, 10, nb, nd, ne);
        chk("R10", "wrong key: busy", nb, 0);
        chk("R10", "wrong key: lock-error", ne, 0);
        dbg_key_i = MAGIC;
        @(negedge clk); dbg_mass_req_i = 2'b10;
        @(negedge clk); dbg_mass_req_i = 2'b00;
        // first busy cycle falls on the request-drop sample, so 3-1 remain
        observe(1, 12, nb2, nd2, ne2);
        chk("R10", "debug erase busy", nb2, 2);
        chk("R10", "debug erase done", nd2, 1);
        chk("R10", "debug erase no lock-error", ne2, 0);

        summary_and_end();
    end

endmodule